// File: doc/BRIEF.md
# Saturating Add/Subtract/Double Unit

This block does signed saturating arithmetic on two operands of equal width (32 bits by default). It has four operations, picked by a two-bit select: add, subtract, add of the doubled second operand, and subtract of the doubled second operand. Any signed overflow makes the result clamp to the largest or smallest representable value instead of wrapping around.

In the two doubling forms, the second operand is first doubled. The doubling has its own overflow check and clamp. The doubled, clamped value then goes through the ordinary add or subtract, which has a second overflow check. Either check sets a sticky saturation flag. That flag can therefore be raised even when the final sum is in range. The flag stays set until a dedicated clear input drops it.

The result and the flag are registered and appear one clock after the inputs. Register-file access and instruction decode live outside this block.

Top module: `sat_arith_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the result is 0 and the saturation flag is 0.
- R2: With select 2'b00 the result one clock later equals A+B if that sum fits in the signed range, otherwise it is clamped.
- R3: With select 2'b01 the result one clock later equals A-B, clamped on signed overflow.
- R4: With select 2'b10 the second operand is doubled and clamped on its own, then added to A with a second clamp.
- R5: With select 2'b11 the second operand is doubled and clamped on its own, then subtracted from A with a second clamp.
- R6: An overflow toward positive values yields 0111...1. An overflow toward negative values yields 1000...0. The direction follows the sign of the wrapped sum: a wrapped value with MSB 1 gives the maximum, and one with MSB 0 gives the minimum.
- R7: A clamp in the doubling step raises the saturation flag even when the final add or subtract stays in range.
- R8: A cycle with any saturation event sets the flag on the next clock. Once set, the flag stays set while the clear input is low.
- R9: With the clear input high, the flag reads 0 on the next clock unless a saturation event happens in that same cycle, in which case it reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation select: 00 add, 01 sub, 10 doubled add, 11 doubled sub |
| a_i | input | WIDTH | First operand, two's complement |
| b_i | input | WIDTH | Second operand, two's complement |
| sat_clr_i | input | 1 | Clears the sticky saturation flag |
| result_o | output | WIDTH | Registered clamped result |
| sat_flag_o | output | 1 | Sticky saturation flag |

## Verification
The bench builds two copies of the unit. One has WIDTH=4, which makes all 16x16 operand pairs under all four selects reachable. That sweep covers every overflow direction, every case where the doubling clamps but the final sum does not, and B at the most negative value. The clear input follows a fixed pattern across the sweep, so flag set, hold and clear-with-saturation all occur. A second copy at WIDTH=32 checks the same boundary cases at the full default width against arithmetic computed in the bench.

// File: rtl/sat_pkg.sv
package sat_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_DADD = 2'b10,
        OP_DSUB = 2'b11
    } sat_op_e;

    function automatic logic op_doubles(input sat_op_e op);
        return (op == OP_DADD) || (op == OP_DSUB);
    endfunction

    function automatic logic op_subtracts(input sat_op_e op);
        return (op == OP_SUB) || (op == OP_DSUB);
    endfunction

endpackage

// File: rtl/sat_addsub.sv
module sat_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] z_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;
    localparam logic [WIDTH-1:0] MAX_V = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] MIN_V = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] wrap;
    logic             y_sign_eff;

    always_comb begin
        wrap       = sub_i ? (x_i - y_i) : (x_i + y_i);
        y_sign_eff = sub_i ? ~y_i[MSB] : y_i[MSB];
        ovf_o      = (x_i[MSB] == y_sign_eff) && (wrap[MSB] != x_i[MSB]);
        // wrapped MSB set means the true value was positive
        z_o        = ovf_o ? (wrap[MSB] ? MAX_V : MIN_V) : wrap;
    end
endmodule

// File: rtl/sat_arith_unit.sv
module sat_arith_unit
    import sat_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [1:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sat_clr_i,
    output logic [WIDTH-1:0] result_o,
    output logic             sat_flag_o
);
    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             flag;
    } state_t;

    state_t state_d, state_q;

    sat_op_e          op;
    logic             dbl_sel;
    logic             sub_sel;
    logic [WIDTH-1:0] b_dbl;
    logic             dbl_ovf;
    logic [WIDTH-1:0] operand;
    logic [WIDTH-1:0] fin_res;
    logic             fin_ovf;
    logic             sat_any;

    assign op      = sat_op_e'(op_i);
    assign dbl_sel = op_doubles(op);
    assign sub_sel = op_subtracts(op);

    sat_addsub #(.WIDTH(WIDTH)) u_double (
        .x_i   (b_i),
        .y_i   (b_i),
        .sub_i (1'b0),
        .z_o   (b_dbl),
        .ovf_o (dbl_ovf)
    );

    assign operand = dbl_sel ? b_dbl : b_i;

    sat_addsub #(.WIDTH(WIDTH)) u_final (
        .x_i   (a_i),
        .y_i   (operand),
        .sub_i (sub_sel),
        .z_o   (fin_res),
        .ovf_o (fin_ovf)
    );

    always_comb begin
        sat_any       = (dbl_sel & dbl_ovf) | fin_ovf;
        state_d       = state_q;
        state_d.res   = fin_res;
        state_d.flag  = sat_any | (state_q.flag & ~sat_clr_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result_o   = state_q.res;
    assign sat_flag_o = state_q.flag;
endmodule

// File: rtl/sat_arith_checker.sv
module sat_arith_checker #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       op,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             clr,
    input logic [WIDTH-1:0] result,
    input logic             flag,
    input logic             sat_evt,
    input logic             fin_ovf
);
    localparam logic [WIDTH-1:0] MAX_V = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] MIN_V = {1'b1, {(WIDTH-1){1'b0}}};

    always_comb begin
        if (!rst_n) begin
            assert_reset_R1: assert (result == '0 && flag == 1'b0);
        end
    end

    assert_add_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b00 && !sat_evt) |=> (result == $past(a + b)));

    assert_sub_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b01 && !sat_evt) |=> (result == $past(a - b)));

    assert_clamp_extreme_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fin_ovf |=> (result == MAX_V || result == MIN_V));

    assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sat_evt |=> flag);

    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !sat_evt) |=> !flag);
endmodule

bind sat_arith_unit sat_arith_checker #(.WIDTH(WIDTH)) u_sat_chk (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .op      (op_i),
    .a       (a_i),
    .b       (b_i),
    .clr     (sat_clr_i),
    .result  (result_o),
    .flag    (sat_flag_o),
    .sat_evt (sat_any),
    .fin_ovf (fin_ovf)
);

// File: tb/sat_arith_unit_bench.sv
module sat_arith_unit_bench;
    localparam int NW = 4;
    localparam int WW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [1:0]    n_op = '0, w_op = '0;
    logic [NW-1:0] n_a = '0, n_b = '0, n_res;
    logic [WW-1:0] w_a = '0, w_b = '0, w_res;
    logic          n_clr = 1'b0, w_clr = 1'b0, n_flag, w_flag;

    int errors = 0;
    int checks = 0;
    bit n_sticky = 1'b0;
    bit w_sticky = 1'b0;

    sat_arith_unit #(.WIDTH(NW)) u_sat_arith_unit (
        .clk_i(clk), .rst_ni(rst_n), .op_i(n_op), .a_i(n_a), .b_i(n_b),
        .sat_clr_i(n_clr), .result_o(n_res), .sat_flag_o(n_flag));

    sat_arith_unit #(.WIDTH(WW)) u_sat_arith_unit_wide (
        .clk_i(clk), .rst_ni(rst_n), .op_i(w_op), .a_i(w_a), .b_i(w_b),
        .sat_clr_i(w_clr), .result_o(w_res), .sat_flag_o(w_flag));

    function automatic longint sx(input logic [WW-1:0] v, input int w);
        longint r = longint'(v) & ((64'sd1 <<< w) - 1);
        if (r[w-1]) r = r - (64'sd1 <<< w);
        return r;
    endfunction

    function automatic longint lim_hi(input int w);
        return (64'sd1 <<< (w - 1)) - 1;
    endfunction

    function automatic longint lim_lo(input int w);
        return -(64'sd1 <<< (w - 1));
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input bit wide, input logic [1:0] op,
                        input logic [WW-1:0] a, input logic [WW-1:0] b,
                        input bit clr);
        int     w = wide ? WW : NW;
        longint as = sx(a, w);
        longint bs = sx(b, w);
        longint d = bs;
        longint f;
        bit     dsat = 1'b0;
        bit     fsat = 1'b0;
        longint exp_res;
        bit     exp_flag;
        string  rq;
        string  fq;
        @(negedge clk);
        if (wide) begin w_op = op; w_a = a; w_b = b; w_clr = clr; end
        else begin n_op = op; n_a = a[NW-1:0]; n_b = b[NW-1:0]; n_clr = clr; end
        if (op[1]) begin
            d = 2 * bs;
            if (d > lim_hi(w)) begin d = lim_hi(w); dsat = 1'b1; end
            if (d < lim_lo(w)) begin d = lim_lo(w); dsat = 1'b1; end
        end
        f = op[0] ? as - d : as + d;
        // R6: clamp direction follows the sign of the true value
        if (f > lim_hi(w)) begin f = lim_hi(w); fsat = 1'b1; end
        if (f < lim_lo(w)) begin f = lim_lo(w); fsat = 1'b1; end
        exp_res = f;
        if (wide) begin
            w_sticky = dsat | fsat | (w_sticky & ~clr);
            exp_flag = w_sticky;
        end else begin
            n_sticky = dsat | fsat | (n_sticky & ~clr);
            exp_flag = n_sticky;
        end
        case (op)
            2'b00: rq = fsat ? "R2/R6" : "R2";
            2'b01: rq = fsat ? "R3/R6" : "R3";
            2'b10: rq = fsat ? "R4/R6" : "R4";
            default: rq = fsat ? "R5/R6" : "R5";
        endcase
        if (clr) fq = "R9";
        else if (dsat && !fsat) fq = "R7";
        else fq = "R8";
        @(posedge clk);
        #1;
        if (wide) begin
            check(rq, sx(w_res, w), exp_res);
            check(fq, longint'(w_flag), longint'(exp_flag));
        end else begin
            check(rq, sx({{(WW-NW){1'b0}}, n_res}, w), exp_res);
            check(fq, longint'(n_flag), longint'(exp_flag));
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int idx = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", longint'(n_res), 0);
        check("R1", longint'(n_flag), 0);
        check("R1", longint'(w_res), 0);
        check("R1", longint'(w_flag), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", longint'(n_res), 0);
        check("R1", longint'(n_flag), 0);

        for (int op = 0; op < 4; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    step(1'b0, 2'(op), WW'(a), WW'(b), (idx % 5) == 0);
                    idx++;
                end
            end
        end

        // R7: doubling clamps, final add stays in range
        step(1'b1, 2'b00, 32'h0, 32'h0, 1'b1);
        step(1'b1, 2'b10, 32'h8000_0000, 32'h4000_0000, 1'b0);
        step(1'b1, 2'b00, 32'h1, 32'h1, 1'b0);
        step(1'b1, 2'b00, 32'h7FFF_FFFF, 32'h1, 1'b1);
        step(1'b1, 2'b01, 32'h8000_0000, 32'h1, 1'b1);
        step(1'b1, 2'b11, 32'h0, 32'hC000_0000, 1'b1);
        step(1'b1, 2'b11, 32'h1234_5678, 32'h0000_1000, 1'b1);
        step(1'b1, 2'b10, 32'hFFFF_FFFF, 32'hBFFF_FFFF, 1'b1);
        step(1'b1, 2'b01, 32'h5, 32'h8000_0000, 1'b0);
        step(1'b1, 2'b00, 32'h3, 32'h4, 1'b0);
        step(1'b1, 2'b00, 32'h3, 32'h4, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule